// File: doc/BRIEF.md
# Instruction Byte Alignment Queue

This block sits between an instruction fetch path that delivers sixteen bytes per cycle and three parallel instruction decoders. Fetched bytes arrive together with three predecode marks per byte: a start mark on the first byte of an instruction, an end mark on its last byte, and a branch mark. The block keeps up to 24 bytes, held as three 8-byte entries. Every cycle it looks at one linear byte window: the held bytes first, then the bytes of the fetch packet accepted in that same cycle. From this window it cuts up to three complete variable-length instructions and places each one, starting at byte 0, on its own decoder lane.

Because an accepted packet joins the window in the cycle it arrives, a packet that reaches an empty queue is decoded at once, with no cycle spent in storage. Any byte of the window can feed any byte of any lane, so an instruction may begin at any byte position. It may also span entry boundaries or the seam between held and incoming bytes. When the decoders accept a group, the bytes it used leave the head of the queue, and the bytes left over move down to the head.

Both streams use valid/ready. The fetch side moves a packet only in a cycle where `in_valid` and `in_ready` are both high, and the upstream source must hold the packet while `in_ready` is low. The decoder side offers `slot_valid`. The whole group is taken in a cycle where `dec_ready` is high. While `dec_ready` is low, the group stays on the lanes and no bytes leave the queue. `flush` is a plain control input.

Top module: `instr_align_queue`

## Requirements
- R1: After reset the queue is empty: with no fetch offered, every lane is invalid and `in_ready` is 1.
- R2: A packet accepted while the queue is empty feeds the lanes in the same cycle.
- R3: Lanes are filled in program order. Lane 0 carries the oldest instruction, and lane k is valid only if lane k-1 is valid. At most three instructions go out per cycle.
- R4: An instruction begins at a byte with a start mark and ends at the first byte at or after it with an end mark, which gives a length of 1 to 15. Lane k holds instruction byte j in bits `slot_bytes[(15*k+j)*8 +: 8]`, with byte 0 at j=0. Bytes past the length are zero, and the length is in `slot_len[4*k +: 4]`.
- R5: An instruction whose end mark has not yet arrived is not issued. It waits, and no later instruction is issued ahead of it.
- R6: While `dec_ready` is 0, the lanes keep showing the same instructions and no byte is removed.
- R7: `in_ready` is 1 exactly when at most 8 bytes are held and `flush` is 0. A packet offered while `in_ready` is 0 is not taken.
- R8: While `flush` is 1, all lanes are invalid and `in_ready` is 0. In the next cycle the queue is empty.
- R9: A lane's branch flag is 1 when any byte of its instruction has the branch mark.
- R10: If the byte at the head of the window has no start mark, no lane is valid.
- R11: An instruction whose bytes are split between held bytes and the incoming packet is issued as one instruction in the cycle the packet arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue and blocks both streams for that cycle |
| in_valid | input | 1 | Fetch packet is offered |
| in_ready | output | 1 | Queue can take a full packet this cycle |
| in_bytes | input | 128 | Fetch packet, byte i in bits [8i+7:8i] |
| in_start | input | 16 | Start mark per packet byte |
| in_end | input | 16 | End mark per packet byte |
| in_branch | input | 16 | Branch mark per packet byte |
| dec_ready | input | 1 | Decoders take the offered group |
| slot_valid | output | 3 | Lane holds a complete instruction |
| slot_len | output | 12 | Length per lane, 4 bits each |
| slot_branch | output | 3 | Branch mark seen within lane's instruction |
| slot_bytes | output | 360 | Aligned instruction bytes, 15 per lane |

## Verification
The two functions that meet in one cycle are extraction from held bytes and the pass-through of a fresh packet. One case is an instruction that starts in storage and ends in the incoming packet, so both sources feed the same lane in one cycle. The bench builds this case with a 15-byte instruction followed by one whose first byte is the last of a packet, and again with exactly 8 held bytes, the largest amount for which `in_ready` is still 1. It judges each case by comparing every lane byte, length and branch flag in that same cycle with the instruction table the bench built. It also checks that a packet offered during a flush or under back-pressure never shows up on a lane.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic br;
  } mark_t;
endpackage

// File: rtl/aq_window.sv
// Joins held bytes with the packet accepted this cycle into one linear window.
module aq_window #(
  parameter int QBYTES      = 24,
  parameter int FETCH_BYTES = 16,
  parameter int CW          = 5
) (
  input  aq_pkg::byte_t [QBYTES-1:0]      q_bytes,
  input  aq_pkg::mark_t [QBYTES-1:0]      q_marks,
  input  logic [CW-1:0]                   q_cnt,
  input  logic                            take,
  input  aq_pkg::byte_t [FETCH_BYTES-1:0] f_bytes,
  input  aq_pkg::mark_t [FETCH_BYTES-1:0] f_marks,
  output aq_pkg::byte_t [QBYTES-1:0]      w_bytes,
  output aq_pkg::mark_t [QBYTES-1:0]      w_marks,
  output logic [CW-1:0]                   w_avail
);
  localparam int FW = (FETCH_BYTES > 1) ? $clog2(FETCH_BYTES) : 1;

  always_comb begin
    for (int i = 0; i < QBYTES; i++) begin
      int rel;
      rel = i - int'(q_cnt);
      w_bytes[i] = '0;
      w_marks[i] = '0;
      if (rel < 0) begin
        w_bytes[i] = q_bytes[i];
        w_marks[i] = q_marks[i];
      end else if (take && rel < FETCH_BYTES) begin
        w_bytes[i] = f_bytes[rel[FW-1:0]];
        w_marks[i] = f_marks[rel[FW-1:0]];
      end
    end
    w_avail = q_cnt + (take ? CW'(FETCH_BYTES) : '0);
  end
endmodule

// File: rtl/aq_lane.sv
// One decoder lane: finds the instruction at pos and aligns it to byte 0.
module aq_lane #(
  parameter int QBYTES  = 24,
  parameter int MAX_LEN = 15,
  parameter int CW      = 5,
  parameter int LW      = 4
) (
  input  aq_pkg::byte_t [QBYTES-1:0]  w_bytes,
  input  aq_pkg::mark_t [QBYTES-1:0]  w_marks,
  input  logic [CW-1:0]               w_avail,
  input  logic [CW-1:0]               pos,
  input  logic                        chain_ok,
  output logic                        ok,
  output logic [LW-1:0]               len,
  output aq_pkg::byte_t [MAX_LEN-1:0] bytes,
  output logic                        br,
  output logic [CW-1:0]               next_pos
);
  localparam int IW = (QBYTES > 1) ? $clog2(QBYTES) : 1;

  logic found;
  logic head_ok;

  always_comb begin
    int p;
    p = int'(pos);
    found = 1'b0;
    len = '0;
    for (int j = 0; j < MAX_LEN; j++) begin
      int idx;
      idx = p + j;
      if (!found && idx < int'(w_avail) && idx < QBYTES) begin
        if (w_marks[idx[IW-1:0]].stop) begin
          found = 1'b1;
          len = LW'(j + 1);
        end
      end
    end
    head_ok = (p < int'(w_avail)) && (p < QBYTES) && w_marks[p[IW-1:0]].start;
    ok = chain_ok && head_ok && found;
    br = 1'b0;
    for (int j = 0; j < MAX_LEN; j++) begin
      int idx;
      idx = p + j;
      bytes[j] = '0;
      if (ok && j < int'(len) && idx < QBYTES) begin
        bytes[j] = w_bytes[idx[IW-1:0]];
        br = br | w_marks[idx[IW-1:0]].br;
      end
    end
    next_pos = ok ? pos + CW'(len) : pos;
  end
endmodule

// File: rtl/aq_store.sv
// Held bytes: drops consumed bytes and moves the remainder to the head.
module aq_store #(
  parameter int QBYTES = 24,
  parameter int CW     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  aq_pkg::byte_t [QBYTES-1:0] w_bytes,
  input  aq_pkg::mark_t [QBYTES-1:0] w_marks,
  input  logic [CW-1:0]              w_avail,
  input  logic [CW-1:0]              consume,
  output aq_pkg::byte_t [QBYTES-1:0] q_bytes,
  output aq_pkg::mark_t [QBYTES-1:0] q_marks,
  output logic [CW-1:0]              q_cnt
);
  localparam int IW = (QBYTES > 1) ? $clog2(QBYTES) : 1;

  aq_pkg::byte_t [QBYTES-1:0] nb;
  aq_pkg::mark_t [QBYTES-1:0] nm;

  always_comb begin
    for (int i = 0; i < QBYTES; i++) begin
      int src;
      src = i + int'(consume);
      nb[i] = '0;
      nm[i] = '0;
      if (src < QBYTES) begin
        nb[i] = w_bytes[src[IW-1:0]];
        nm[i] = w_marks[src[IW-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      q_cnt   <= '0;
      q_bytes <= '0;
      q_marks <= '0;
    end else begin
      q_cnt   <= w_avail - consume;
      q_bytes <= nb;
      q_marks <= nm;
    end
  end
endmodule

// File: rtl/instr_align_queue.sv
module instr_align_queue #(
  parameter int ENTRY_BYTES = 8,
  parameter int NUM_ENTRIES = 3,
  parameter int FETCH_BYTES = 16,
  parameter int LANES       = 3,
  parameter int MAX_LEN     = 15,
  localparam int QBYTES     = ENTRY_BYTES * NUM_ENTRIES,
  localparam int CW         = $clog2(QBYTES + 1),
  localparam int LW         = $clog2(MAX_LEN + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [FETCH_BYTES*8-1:0]     in_bytes,
  input  logic [FETCH_BYTES-1:0]       in_start,
  input  logic [FETCH_BYTES-1:0]       in_end,
  input  logic [FETCH_BYTES-1:0]       in_branch,
  input  logic                         dec_ready,
  output logic [LANES-1:0]             slot_valid,
  output logic [LANES*LW-1:0]          slot_len,
  output logic [LANES-1:0]             slot_branch,
  output logic [LANES*MAX_LEN*8-1:0]   slot_bytes
);
  aq_pkg::byte_t [FETCH_BYTES-1:0] f_bytes;
  aq_pkg::mark_t [FETCH_BYTES-1:0] f_marks;
  aq_pkg::byte_t [QBYTES-1:0]      q_bytes, w_bytes;
  aq_pkg::mark_t [QBYTES-1:0]      q_marks, w_marks;
  logic [CW-1:0]                   q_cnt, w_avail, consume;
  logic                            take;
  logic [CW-1:0]                   lane_pos [LANES+1];
  logic [LANES:0]                  chain;

  always_comb begin
    for (int i = 0; i < FETCH_BYTES; i++) begin
      f_bytes[i]       = in_bytes[i*8 +: 8];
      f_marks[i].start = in_start[i];
      f_marks[i].stop  = in_end[i];
      f_marks[i].br    = in_branch[i];
    end
  end

  assign in_ready = !flush && (q_cnt <= CW'(QBYTES - FETCH_BYTES));
  assign take     = in_valid && in_ready;

  aq_window #(.QBYTES(QBYTES), .FETCH_BYTES(FETCH_BYTES), .CW(CW)) u_win (
    .q_bytes(q_bytes), .q_marks(q_marks), .q_cnt(q_cnt), .take(take),
    .f_bytes(f_bytes), .f_marks(f_marks),
    .w_bytes(w_bytes), .w_marks(w_marks), .w_avail(w_avail)
  );

  assign lane_pos[0] = '0;
  assign chain[0]    = !flush;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    aq_pkg::byte_t [MAX_LEN-1:0] lb;
    logic [LW-1:0]               ll;
    logic                        lok;
    logic                        lbr;

    aq_lane #(.QBYTES(QBYTES), .MAX_LEN(MAX_LEN), .CW(CW), .LW(LW)) u_lane (
      .w_bytes(w_bytes), .w_marks(w_marks), .w_avail(w_avail),
      .pos(lane_pos[k]), .chain_ok(chain[k]),
      .ok(lok), .len(ll), .bytes(lb), .br(lbr), .next_pos(lane_pos[k+1])
    );

    assign chain[k+1]                         = lok;
    assign slot_valid[k]                      = lok;
    assign slot_len[k*LW +: LW]               = ll;
    assign slot_branch[k]                     = lbr;
    assign slot_bytes[k*MAX_LEN*8 +: MAX_LEN*8] = lb;
  end

  assign consume = (dec_ready && !flush) ? lane_pos[LANES] : '0;

  aq_store #(.QBYTES(QBYTES), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .w_bytes(w_bytes), .w_marks(w_marks), .w_avail(w_avail), .consume(consume),
    .q_bytes(q_bytes), .q_marks(q_marks), .q_cnt(q_cnt)
  );
endmodule

// File: rtl/aq_checker.sv
module aq_checker #(
  parameter int LANES   = 3,
  parameter int MAX_LEN = 15,
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                in_valid,
  input logic                in_ready,
  input logic                dec_ready,
  input logic [LANES-1:0]    slot_valid,
  input logic [LANES*LW-1:0] slot_len
);
  for (genvar k = 1; k < LANES; k++) begin : g_order
    assert_lane_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> slot_valid[k-1]);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_len
    assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> (slot_len[k*LW +: LW] != '0 && slot_len[k*LW +: LW] <= LW'(MAX_LEN)));
  end

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (slot_valid == '0 && !in_ready));

  assert_empty_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && !flush && !in_valid) |-> (slot_valid == '0 && in_ready));

  assert_hold_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot_valid[0] && !dec_ready && !flush) && !flush)
      |-> (slot_valid[0] && $stable(slot_len[LW-1:0])));
endmodule

bind instr_align_queue aq_checker #(.LANES(LANES), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_ready(in_ready), .dec_ready(dec_ready),
  .slot_valid(slot_valid), .slot_len(slot_len)
);

// File: tb/tb_instr_align_queue.sv
module tb_instr_align_queue;
  localparam int FB = 16;
  localparam int NL = 3;
  localparam int ML = 15;

  logic clk = 1'b0;
  logic rst_n, flush, in_valid, in_ready, dec_ready;
  logic [FB*8-1:0]  in_bytes;
  logic [FB-1:0]    in_start, in_end, in_branch;
  logic [NL-1:0]    slot_valid, slot_branch;
  logic [NL*4-1:0]  slot_len;
  logic [NL*ML*8-1:0] slot_bytes;

  int checks = 0;
  int failures = 0;

  logic [7:0] s_byte [128];
  logic       s_st [128];
  logic       s_en [128];
  logic       s_br [128];
  int i_off [32];
  int i_len [32];
  bit i_br  [32];
  int n_inst, w_ptr, r_ptr;

  always #4 clk = ~clk;

  instr_align_queue dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_start(in_start), .in_end(in_end), .in_branch(in_branch),
    .dec_ready(dec_ready), .slot_valid(slot_valid), .slot_len(slot_len),
    .slot_branch(slot_branch), .slot_bytes(slot_bytes)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic reset_stream();
    for (int i = 0; i < 128; i++) begin
      s_byte[i] = '0; s_st[i] = 0; s_en[i] = 0; s_br[i] = 0;
    end
    n_inst = 0; w_ptr = 0; r_ptr = 0;
  endtask

  task automatic add_inst(input int len, input bit br);
    i_off[n_inst] = w_ptr; i_len[n_inst] = len; i_br[n_inst] = br;
    for (int j = 0; j < len; j++) begin
      s_byte[w_ptr+j] = 8'((w_ptr + j) * 7 + 3);
      s_st[w_ptr+j]   = (j == 0);
      s_en[w_ptr+j]   = (j == len - 1);
      s_br[w_ptr+j]   = br && (j == len / 2);
    end
    w_ptr += len;
    n_inst++;
  endtask

  task automatic load_pkt();
    in_valid = 1'b1;
    for (int i = 0; i < FB; i++) begin
      in_bytes[i*8 +: 8] = s_byte[r_ptr+i];
      in_start[i]  = s_st[r_ptr+i];
      in_end[i]    = s_en[r_ptr+i];
      in_branch[i] = s_br[r_ptr+i];
    end
    r_ptr += FB;
  endtask

  task automatic check_lane(input string req, input int k, input int n);
    int bad;
    chk(req, $sformatf("lane%0d valid", k), int'(slot_valid[k]), 1);
    chk(req, $sformatf("lane%0d len", k), int'(slot_len[k*4 +: 4]), i_len[n]);
    chk("R9", $sformatf("lane%0d branch", k), int'(slot_branch[k]), int'(i_br[n]));
    bad = 0;
    for (int j = 0; j < ML; j++) begin
      int e;
      e = (j < i_len[n]) ? int'(s_byte[i_off[n]+j]) : 0;
      if (int'(slot_bytes[(k*ML+j)*8 +: 8]) != e && bad == 0) begin
        bad = 1;
        chk(req, $sformatf("lane%0d byte%0d", k, j), int'(slot_bytes[(k*ML+j)*8 +: 8]), e);
      end
    end
    if (bad == 0) chk(req, $sformatf("lane%0d bytes", k), 0, 0);
  endtask

  task automatic do_flush();
    flush = 1'b1; in_valid = 1'b0;
    #1;
    chk("R8", "lanes during flush", int'(slot_valid), 0);
    chk("R8", "in_ready during flush", int'(in_ready), 0);
    next();
    flush = 1'b0;
    reset_stream();
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "lanes after reset", int'(slot_valid), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_passthrough();
    reset_stream();
    add_inst(3, 1); add_inst(4, 0); add_inst(5, 0); add_inst(4, 1);
    dec_ready = 1'b1;
    load_pkt();
    #1;
    check_lane("R2", 0, 0);
    check_lane("R3", 1, 1);
    check_lane("R4", 2, 2);
    next();
    in_valid = 1'b0;
    #1;
    check_lane("R3", 0, 3);
    chk("R3", "lane1 after tail", int'(slot_valid[1]), 0);
    next();
    #1;
    chk("R1", "lanes once drained", int'(slot_valid), 0);
  endtask

  task automatic t_partial_seam();
    do_flush();
    add_inst(15, 0); add_inst(10, 1); add_inst(7, 0);
    dec_ready = 1'b1;
    load_pkt();
    #1;
    check_lane("R4", 0, 0);
    chk("R5", "incomplete instruction held", int'(slot_valid[1]), 0);
    next();
    load_pkt();
    #1;
    check_lane("R11", 0, 1);
    check_lane("R11", 1, 2);
    chk("R3", "lane2 idle", int'(slot_valid[2]), 0);
    next();
    in_valid = 1'b0;
    #1;
    chk("R5", "nothing left", int'(slot_valid), 0);
  endtask

  task automatic t_hold();
    do_flush();
    add_inst(2, 0); add_inst(2, 1); add_inst(2, 0); add_inst(2, 0); add_inst(8, 1);
    dec_ready = 1'b0;
    load_pkt();
    #1;
    check_lane("R6", 0, 0);
    check_lane("R6", 1, 1);
    check_lane("R6", 2, 2);
    next();
    load_pkt();
    #1;
    chk("R7", "in_ready with 16 held", int'(in_ready), 0);
    check_lane("R6", 0, 0);
    check_lane("R6", 2, 2);
    next();
    in_valid = 1'b0; dec_ready = 1'b1;
    #1;
    check_lane("R6", 0, 0);
    next();
    #1;
    check_lane("R7", 0, 3);
    check_lane("R7", 1, 4);
    chk("R7", "offered packet not taken", int'(slot_valid[2]), 0);
    chk("R7", "in_ready with 10 held", int'(in_ready), 0);
    next();
    #1;
    chk("R7", "in_ready when empty", int'(in_ready), 1);
    chk("R7", "lanes when empty", int'(slot_valid), 0);
  endtask

  task automatic t_eight_held();
    do_flush();
    add_inst(8, 0); add_inst(12, 1);
    dec_ready = 1'b1;
    load_pkt();
    #1;
    check_lane("R5", 0, 0);
    chk("R5", "lane1 waits", int'(slot_valid[1]), 0);
    next();
    in_valid = 1'b0;
    #1;
    chk("R7", "in_ready with 8 held", int'(in_ready), 1);
    chk("R5", "partial not issued", int'(slot_valid), 0);
    load_pkt();
    #1;
    check_lane("R11", 0, 1);
    next();
    in_valid = 1'b0;
    #1;
    chk("R11", "drained", int'(slot_valid), 0);
  endtask

  task automatic t_flush();
    do_flush();
    add_inst(4, 0); add_inst(4, 0); add_inst(4, 0); add_inst(4, 0); add_inst(4, 1);
    dec_ready = 1'b0;
    load_pkt();
    #1;
    check_lane("R8", 0, 0);
    next();
    flush = 1'b1;
    load_pkt();
    #1;
    chk("R8", "lanes in flush", int'(slot_valid), 0);
    chk("R8", "in_ready in flush", int'(in_ready), 0);
    next();
    flush = 1'b0; in_valid = 1'b0; dec_ready = 1'b1;
    #1;
    chk("R8", "lanes after flush", int'(slot_valid), 0);
    chk("R8", "in_ready after flush", int'(in_ready), 1);
  endtask

  task automatic t_no_start();
    reset_stream();
    add_inst(5, 0); add_inst(3, 0);
    s_st[0] = 1'b0;
    load_pkt();
    #1;
    chk("R10", "head without start mark", int'(slot_valid), 0);
    next();
    do_flush();
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; dec_ready = 1'b1;
    in_bytes = '0; in_start = '0; in_end = '0; in_branch = '0;
    reset_stream();
    repeat (3) next();
    rst_n = 1'b1;
    t_reset();
    next();
    t_passthrough();
    next();
    t_partial_seam();
    next();
    t_hold();
    next();
    t_eight_held();
    next();
    t_flush();
    next();
    t_no_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule